// File: doc/BRIEF.md
# Packed Lane Rounding Shifter

This block shifts every lane of a packed data word by its own signed amount. A positive amount shifts the lane left and drops the bits that leave the top. A negative amount shifts it right and rounds to the nearest value, with halves going upward. The rounding step never wraps, even when the lane already holds its largest value. A select input picks 8-, 16-, 32- or 64-bit lanes. A second input picks signed (arithmetic) or unsigned (logical) handling. Shift amounts that reach or pass the lane width follow fixed corner rules.

An operation is presented with `valid_i` for one cycle. The result is registered and appears with `valid_o` on the next cycle. A two-state machine tracks the output stage. In `ST_IDLE` no result is being offered, and in `ST_OUT` a fresh result is being offered. The transition `T_ACCEPT` (any state to `ST_OUT`) is taken when `valid_i` is high. The transition `T_DRAIN` (any state to `ST_IDLE`) is taken when `valid_i` is low. While idle, the result register keeps its last value.

Top module: `rvs_unit`

## Requirements
- R1: After reset, `valid_o` is 0 and `result_o` is all zeros. `valid_o` is high in exactly the cycle after each cycle in which `valid_i` is high.
- R2: Each lane reads its shift amount from bits [7:0] of the matching lane of `amount_i`, as a signed 8-bit value. Lanes with different amounts are computed independently.
- R3: For an amount n with 0 ≤ n < W, where W is the lane width, the lane result is the lane value shifted left by n with the high bits discarded.
- R4: For an amount −n with 1 ≤ n ≤ W, the lane result is floor((v + 2^(n−1)) / 2^n), computed without wrap. For example, an unsigned 64-bit lane of all ones shifted by −1 gives 0x8000000000000000.
- R5: An amount n ≥ W gives a lane result of 0.
- R6: An amount of exactly −W gives the top bit of the lane for unsigned lanes and 0 for signed lanes.
- R7: An amount below −W gives 0 for unsigned lanes. For signed lanes it gives the sign copied into every bit: all ones if the lane is negative, otherwise 0.
- R8: With `is_signed_i` = 1, the lane value v is read as two's complement, so right shifts are arithmetic. With `is_signed_i` = 0, v is read as unsigned, so right shifts are logical.
- R9: `lane_sz_i` selects the lane width: 0 → 8, 1 → 16, 2 → 32, 3 → 64. Lanes are packed from bit 0 upward.
- R10: In a cycle after one in which `valid_i` is low, `result_o` equals its value from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| is_signed_i | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| lane_sz_i | input | 2 | Lane width code |
| operand_i | input | DATA_W | Packed lane values |
| amount_i | input | DATA_W | Packed shift amounts; low byte of each lane is used |
| valid_o | output | 1 | Result valid |
| result_o | output | DATA_W | Packed shifted lanes |

## Verification
Every result is due exactly one rising edge after the cycle in which `valid_i` was high. The bench drives each operation on a falling edge and drops `valid_i` on the next falling edge. At that same point, half a period after the capturing edge, it compares `valid_o` and `result_o`. To check R10, an extra idle cycle is checked one more falling edge later. In that cycle `valid_o` must be low and `result_o` must be unchanged.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
    typedef enum logic [1:0] {
        LS_8  = 2'd0,
        LS_16 = 2'd1,
        LS_32 = 2'd2,
        LS_64 = 2'd3
    } lane_sz_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } out_state_e;
endpackage

// File: rtl/rvs_lane.sv
module rvs_lane #(
    parameter int LW = 8
) (
    input  logic          sg_i,
    input  logic [LW-1:0] val_i,
    input  logic [7:0]    amt_i,
    output logic [LW-1:0] res_o
);
    logic [8:0]          mag;
    logic signed [LW:0]  ext;
    logic signed [LW:0]  tmp;

    // Magnitude of a negative amount (128 for -128 fits in 9 bits)
    assign mag = 9'd0 - {amt_i[7], amt_i};
    assign ext = {sg_i & val_i[LW-1], val_i};

    always_comb begin
        tmp   = '0;
        res_o = '0;
        if (!amt_i[7]) begin
            if (int'(amt_i[6:0]) >= LW) begin
                res_o = '0;
            end else begin
                res_o = val_i << amt_i[6:0];
            end
        end else if (int'(mag) > LW) begin
            res_o = (sg_i && val_i[LW-1]) ? '1 : '0;
        end else begin
            // Shift by n-1, then halve and add the round bit: no wrap possible
            tmp   = ext >>> (mag - 9'd1);
            res_o = tmp[LW:1] + LW'(tmp[0]);
        end
    end
endmodule

// File: rtl/rvs_lane_array.sv
module rvs_lane_array #(
    parameter int DATA_W = 64,
    parameter int LW     = 8
) (
    input  logic                sg_i,
    input  logic [DATA_W-1:0]   val_i,
    input  logic [NL*8-1:0]     amt_i,
    output logic [DATA_W-1:0]   res_o
);
    localparam int NL = DATA_W / LW;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        rvs_lane #(.LW(LW)) i_lane (
            .sg_i  (sg_i),
            .val_i (val_i[g*LW +: LW]),
            .amt_i (amt_i[g*8 +: 8]),
            .res_o (res_o[g*LW +: LW])
        );
    end
endmodule

// File: rtl/rvs_unit.sv
module rvs_unit #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              is_signed_i,
    input  logic [1:0]        lane_sz_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] amount_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o
);
    import rvs_pkg::*;

    localparam int NSZ = 4;

    logic [DATA_W-1:0] res_sz [NSZ];
    logic [DATA_W-1:0] sel_res;
    logic [DATA_W-1:0] result_q;
    out_state_e        state_q, state_d;

    for (genvar s = 0; s < NSZ; s++) begin : g_size
        localparam int LW = 8 << s;
        localparam int NL = DATA_W / LW;
        logic [NL*8-1:0] amt_b;
        for (genvar k = 0; k < NL; k++) begin : g_amt
            assign amt_b[k*8 +: 8] = amount_i[k*LW +: 8];
        end
        rvs_lane_array #(.DATA_W(DATA_W), .LW(LW)) i_arr (
            .sg_i  (is_signed_i),
            .val_i (operand_i),
            .amt_i (amt_b),
            .res_o (res_sz[s])
        );
    end

    always_comb begin
        unique case (lane_sz_e'(lane_sz_i))
            LS_8:    sel_res = res_sz[0];
            LS_16:   sel_res = res_sz[1];
            LS_32:   sel_res = res_sz[2];
            LS_64:   sel_res = res_sz[3];
            default: sel_res = res_sz[0];
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = valid_i ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = valid_i ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (valid_i) begin
            result_q <= sel_res;
        end
    end

    assign valid_o  = (state_q == ST_OUT);
    assign result_o = result_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(result_o)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && lane_sz_i == 2'd3 && !is_signed_i &&
         operand_i[63:0] == 64'hFFFF_FFFF_FFFF_FFFF && amount_i[7:0] == 8'hFF)
        |=> result_o[63:0] == 64'h8000_0000_0000_0000); // R4
    AST_BIG_LEFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && lane_sz_i == 2'd3 && !amount_i[7] && amount_i[6])
        |=> result_o[63:0] == 64'd0); // R5
    AST_SIGNED_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && lane_sz_i == 2'd3 && is_signed_i && amount_i[7:0] == 8'hC0)
        |=> result_o[63:0] == 64'd0); // R6
endmodule

// File: tb/test_rvs_unit.sv
module test_rvs_unit;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid_i = 1'b0;
    logic              is_signed_i = 1'b0;
    logic [1:0]        lane_sz_i = 2'd0;
    logic [DATA_W-1:0] operand_i = '0;
    logic [DATA_W-1:0] amount_i = '0;
    logic              valid_o;
    logic [DATA_W-1:0] result_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    rvs_unit #(.DATA_W(DATA_W)) i_rvs_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .is_signed_i(is_signed_i),
        .lane_sz_i(lane_sz_i), .operand_i(operand_i), .amount_i(amount_i),
        .valid_o(valid_o), .result_o(result_o)
    );

    // Wide-precision arithmetic model of one lane
    function automatic logic [63:0] ref_lane(logic [63:0] v, int amt, int lw, bit sg);
        logic [63:0]         mask;
        logic signed [129:0] x;
        int                  n;
        mask = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
        v    = v & mask;
        if (amt >= lw) return 64'd0;
        if (amt >= 0) return (v << amt) & mask;
        if (amt < -lw) return (sg && v[lw-1]) ? mask : 64'd0;
        n = -amt;
        x = $signed({66'd0, v});
        if (sg && v[lw-1]) x = x - (130'sd1 <<< lw);
        x = x + (130'sd1 <<< (n - 1));
        x = x >>> n;
        return x[63:0] & mask;
    endfunction

    function automatic logic [63:0] ref_word(logic [63:0] op, logic [63:0] am, int sz, bit sg);
        logic [63:0] r;
        int lw;
        lw = 8 << sz;
        r  = '0;
        for (int k = 0; k < 64 / lw; k++) begin
            logic [63:0] lv;
            lv = (op >> (k * lw));
            r  = r | (ref_lane(lv, int'($signed(am[k*lw +: 8])), lw, sg) << (k * lw));
        end
        return r;
    endfunction

    function automatic string tag_of(int amt, int lw);
        if (amt >= lw) return "R5";
        if (amt >= 0) return "R3";
        if (amt == -lw) return "R6";
        if (amt < -lw) return "R7";
        return "R4";
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge (one register)
    task automatic do_op(logic [63:0] op, logic [63:0] am, int sz, bit sg, string extra);
        logic [63:0] exp;
        @(negedge clk);
        valid_i = 1'b1; is_signed_i = sg; lane_sz_i = 2'(sz);
        operand_i = op; amount_i = am;
        exp = ref_word(op, am, sz, sg);
        @(negedge clk);
        valid_i = 1'b0;
        check({"R1 valid ", extra}, {63'd0, valid_o}, 64'd1);
        check({tag_of(int'($signed(am[7:0])), 8 << sz), " R9 R8 ", extra}, result_o, exp);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL R1 watchdog got=running exp=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] corner [8];
        logic [63:0] lfsr;
        logic [63:0] held;
        corner[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        corner[1] = 64'h8000_0000_0000_0000;
        corner[2] = 64'h7FFF_FFFF_FFFF_FFFF;
        corner[3] = 64'h0000_0000_0000_0001;
        corner[4] = 64'h0000_0000_0000_0000;
        corner[5] = 64'h8080_8080_8080_8080;
        corner[6] = 64'h7F7F_7F7F_7F7F_7F7F;
        corner[7] = 64'hA5C3_0F96_5A3C_F069;

        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, valid_o}, 64'd0);
        check("R1 reset result", result_o, 64'd0);
        rst_n = 1'b1;

        // R8 R4: signed vs unsigned on the same negative lane
        do_op(64'h0000_0000_0000_00F9, 64'h0000_0000_0000_00FE, 0, 1'b1, "signed -7>>2");
        check("R8 signed round", result_o, 64'h0000_0000_0000_00FE);
        do_op(64'h0000_0000_0000_00F9, 64'h0000_0000_0000_00FE, 0, 1'b0, "unsigned 249>>2");
        check("R8 unsigned round", result_o, 64'h0000_0000_0000_003E);

        // R10: idle cycle keeps the result and drops valid
        held = result_o;
        @(negedge clk);
        check("R10 hold", result_o, held);
        check("R1 idle valid", {63'd0, valid_o}, 64'd0);

        // R2: distinct amounts per 16-bit lane
        do_op(64'h1234_1234_1234_1234, 64'h0004_00FC_0010_00F0, 1, 1'b0, "R2 per-lane");
        check("R2 per-lane", result_o, 64'h2340_0123_0000_0000);

        // 8-bit lanes: every amount, sweep of values, staggered per-lane amounts
        for (int b = 0; b < 256; b += 17) begin
            for (int a = 0; a < 256; a++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    logic [63:0] op, am;
                    for (int k = 0; k < 8; k++) begin
                        op[k*8 +: 8] = 8'(b + k * 37);
                        am[k*8 +: 8] = 8'(a + k * 3);
                    end
                    do_op(op, am, 0, sg[0], "sweep8");
                end
            end
        end

        // 16/32/64-bit lanes: every amount over corner values
        lfsr = 64'hC0FF_EE12_3456_789B;
        for (int sz = 1; sz < 4; sz++) begin
            for (int c = 0; c < 8; c++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int sg = 0; sg < 2; sg++) begin
                        logic [63:0] am;
                        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
                        am = lfsr;
                        for (int k = 0; k < 64 / (8 << sz); k++)
                            am[k*(8 << sz) +: 8] = 8'(a + k * 5);
                        do_op(corner[c], am, sz, sg[0], "sweep");
                    end
                end
            end
        end

        // R4: no wrap on rounding of the largest values
        do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00FF, 3, 1'b0, "R4 u64 max");
        check("R4 u64 max", result_o, 64'h8000_0000_0000_0000);
        do_op(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00FF, 3, 1'b1, "R4 s64 max");
        check("R4 s64 max", result_o, 64'h4000_0000_0000_0000);
        do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00FF_0000_00FF, 2, 1'b0, "R4 u32 max");
        check("R4 u32 max", result_o, 64'h8000_0000_8000_0000);
        // R6 / R7 explicit
        do_op(64'h8000_0000_0000_0000, 64'h0000_0000_0000_00C0, 3, 1'b0, "R6 u64");
        check("R6 u64 top bit", result_o, 64'd1);
        do_op(64'h8000_0000_8000_0000, 64'h0000_00DF_0000_00E0, 2, 1'b1, "R7 s32");
        check("R7 R6 s32", result_o, 64'hFFFF_FFFF_0000_0000);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule